// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Qualifier

This block decides whether a raw debug hit should actually be reported to the exception logic. It handles two kinds of hit. An instruction-address breakpoint hit is accepted only when the processor runs at the privilege level chosen by a two-bit privilege code. A data-address watchpoint hit is accepted only when the current privilege is enabled in a watchpoint control word and, unless told to ignore it, the data-translation mode matches the one the control word asks for. Address comparison happens elsewhere. The block receives a one-bit raw hit for each kind.

Each qualified hit is registered and shown for exactly one cycle after the raw hit is sampled. With it the block presents the status pattern the fault handler expects. A watchpoint gives a data-storage status word. A breakpoint gives a trace error-code word. A global enable input blocks both paths.

Top module: `dbq_debug_qualifier`

## Requirements
- R1: While `feat_en` is 0, neither `bp_fire` nor `wp_fire` is ever asserted, whatever the other inputs are.
- R2: Breakpoint privilege code 1 qualifies a breakpoint hit only when `st_pr` is 1.
- R3: Breakpoint privilege code 2 qualifies a breakpoint hit only when `st_pr` is 0 and `st_hv` is 0.
- R4: Breakpoint privilege code 3 qualifies a breakpoint hit only when `st_pr` is 0 and `st_hv` is 1.
- R5: Breakpoint privilege code 0 never qualifies.
- R6: A watchpoint hit is rejected when `st_pr` is 1 and the problem-state enable, `wp_ctl` bit 0 (MSB-0 bit 63), is 0.
- R7: A watchpoint hit is rejected when `st_hv` is 1 and the hypervisor enable, `wp_ctl` bit 2 (MSB-0 bit 61), is 0. It is always rejected when the supervisor enable, `wp_ctl` bit 1 (MSB-0 bit 62), is 0.
- R8: When the translation-ignore flag, `wp_ctl` bit 3 (MSB-0 bit 60), is 0, a watchpoint that passes R6 and R7 qualifies only if the translation-match flag, `wp_ctl` bit 4 (MSB-0 bit 59), equals `st_dr`. When the ignore flag is 1, `st_dr` has no effect.
- R9: `wp_status` equals 64'h0000_0000_0040_0000 (MSB-0 bit 41) in the cycle `wp_fire` is 1. Otherwise it is zero.
- R10: `bp_err` equals 64'h0000_0000_4010_0000 (MSB-0 bits 33 and 43) in the cycle `bp_fire` is 1. Otherwise it is zero.
- R11: A qualified hit sampled at one rising edge shows on its fire output for the following cycle only. If no qualified hit is sampled at the next edge, the output clears.
- R12: While `rst_n` is 0, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Global enable for debug qualification |
| bp_hit | input | 1 | Raw instruction-address breakpoint hit |
| bp_priv | input | 2 | Breakpoint privilege code |
| wp_hit | input | 1 | Raw data-address watchpoint hit |
| wp_ctl | input | 64 | Watchpoint control word |
| st_pr | input | 1 | Processor in problem (user) state |
| st_hv | input | 1 | Processor in hypervisor state |
| st_dr | input | 1 | Data translation enabled |
| bp_fire | output | 1 | Qualified breakpoint, one cycle after the hit |
| wp_fire | output | 1 | Qualified watchpoint, one cycle after the hit |
| wp_status | output | 64 | Data-storage status pattern for a qualified watchpoint |
| bp_err | output | 64 | Trace error-code pattern for a qualified breakpoint |

## Verification
The assertions check four rules on every cycle. A fire output follows a sampled raw hit taken while enabled. Privilege code 0 never produces a breakpoint. A translation-checked watchpoint always had a matching translation bit. The status and error words track their fire bits exactly. Only the bench's scenarios can show the following: every privilege code is accepted or refused across all privilege states, every combination of the watchpoint enable bits is handled correctly, and a report clears once the hit goes away.

// File: rtl/dbq_pkg.sv
package dbq_pkg;

    // Breakpoint privilege selector values.
    typedef enum logic [1:0] {
        PRIV_OFF  = 2'd0,
        PRIV_PROB = 2'd1,
        PRIV_SUP  = 2'd2,
        PRIV_HYP  = 2'd3
    } bp_priv_e;

    // Convert an MSB-0 bit number into an LSB-0 index for a word of width w.
    function automatic int msb0_idx(input int n, input int w);
        return w - 1 - n;
    endfunction

endpackage

// File: rtl/dbq_bp_qual.sv
module dbq_bp_qual
    import dbq_pkg::*;
(
    input  logic [1:0] priv_code,
    input  logic       st_pr,
    input  logic       st_hv,
    output logic       priv_ok
);

    bp_priv_e code;

    always_comb begin
        code = bp_priv_e'(priv_code);
        unique case (code)
            PRIV_PROB: priv_ok = st_pr;
            PRIV_SUP:  priv_ok = !st_pr && !st_hv;
            PRIV_HYP:  priv_ok = !st_pr &&  st_hv;
            default:   priv_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbq_wp_qual.sv
module dbq_wp_qual
    import dbq_pkg::*;
#(
    parameter int CTL_W = 64
) (
    input  logic [CTL_W-1:0] ctl,
    input  logic             st_pr,
    input  logic             st_hv,
    input  logic             st_dr,
    output logic             ctl_ok
);

    localparam int I_XMATCH = msb0_idx(59, CTL_W);
    localparam int I_XIGN   = msb0_idx(60, CTL_W);
    localparam int I_HVEN   = msb0_idx(61, CTL_W);
    localparam int I_SVEN   = msb0_idx(62, CTL_W);
    localparam int I_PREN   = msb0_idx(63, CTL_W);

    logic priv_pass;
    logic xlat_pass;

    always_comb begin
        priv_pass = 1'b1;
        if (st_pr && !ctl[I_PREN]) begin
            priv_pass = 1'b0;
        end
        if (st_hv && !ctl[I_HVEN]) begin
            priv_pass = 1'b0;
        end
        if (!ctl[I_SVEN]) begin
            priv_pass = 1'b0;
        end
        xlat_pass = ctl[I_XIGN] || (ctl[I_XMATCH] == st_dr);
        ctl_ok    = priv_pass && xlat_pass;
    end

endmodule

// File: rtl/dbq_debug_qualifier.sv
module dbq_debug_qualifier
    import dbq_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feat_en,
    input  logic             bp_hit,
    input  logic [1:0]       bp_priv,
    input  logic             wp_hit,
    input  logic [REG_W-1:0] wp_ctl,
    input  logic             st_pr,
    input  logic             st_hv,
    input  logic             st_dr,
    output logic             bp_fire,
    output logic             wp_fire,
    output logic [REG_W-1:0] wp_status,
    output logic [REG_W-1:0] bp_err
);

    localparam int I_STS41 = msb0_idx(41, REG_W);
    localparam int I_ERR33 = msb0_idx(33, REG_W);
    localparam int I_ERR43 = msb0_idx(43, REG_W);
    localparam int I_XMATCH = msb0_idx(59, REG_W);
    localparam int I_XIGN   = msb0_idx(60, REG_W);
    localparam logic [REG_W-1:0] STS_PAT = REG_W'(1) << I_STS41;
    localparam logic [REG_W-1:0] ERR_PAT = (REG_W'(1) << I_ERR33) | (REG_W'(1) << I_ERR43);

    typedef struct packed {
        logic             bp_fire;
        logic             wp_fire;
        logic [REG_W-1:0] wp_status;
        logic [REG_W-1:0] bp_err;
    } state_t;

    state_t st_d, st_q;
    logic   bp_ok, wp_ok;

    dbq_bp_qual u_bp (
        .priv_code (bp_priv),
        .st_pr     (st_pr),
        .st_hv     (st_hv),
        .priv_ok   (bp_ok)
    );

    dbq_wp_qual #(.CTL_W(REG_W)) u_wp (
        .ctl    (wp_ctl),
        .st_pr  (st_pr),
        .st_hv  (st_hv),
        .st_dr  (st_dr),
        .ctl_ok (wp_ok)
    );

    always_comb begin
        st_d           = st_q;
        st_d.bp_fire   = feat_en && bp_hit && bp_ok;
        st_d.wp_fire   = feat_en && wp_hit && wp_ok;
        st_d.bp_err    = st_d.bp_fire ? ERR_PAT : '0;
        st_d.wp_status = st_d.wp_fire ? STS_PAT : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bp_fire   = st_q.bp_fire;
    assign wp_fire   = st_q.wp_fire;
    assign wp_status = st_q.wp_status;
    assign bp_err    = st_q.bp_err;

    // R1: a report needs the enable in the sampled cycle
    a_r1_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_fire || wp_fire) |-> $past(feat_en));

    // R11: a report needs a raw hit one cycle earlier
    a_r11_bp_follows_hit: assert property (@(posedge clk) disable iff (!rst_n)
        bp_fire |-> $past(bp_hit));
    a_r11_wp_follows_hit: assert property (@(posedge clk) disable iff (!rst_n)
        wp_fire |-> $past(wp_hit));

    // R5: code 0 never reports
    a_r5_code_off: assert property (@(posedge clk) disable iff (!rst_n)
        bp_fire |-> ($past(bp_priv) != 2'd0));

    // R2: code 1 reports only in problem state
    a_r2_problem_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_fire && $past(bp_priv) == 2'd1) |-> $past(st_pr));

    // R8: translation-checked watchpoint had matching DR
    a_r8_xlat_match: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_fire && !$past(wp_ctl[I_XIGN])) |-> ($past(wp_ctl[I_XMATCH]) == $past(st_dr)));

    // R9: status tracks the watchpoint report
    a_r9_status: assert property (@(posedge clk) disable iff (!rst_n)
        wp_fire ? (wp_status == STS_PAT) : (wp_status == '0));

    // R10: error code tracks the breakpoint report
    a_r10_errcode: assert property (@(posedge clk) disable iff (!rst_n)
        bp_fire ? (bp_err == ERR_PAT) : (bp_err == '0));

endmodule

// File: tb/dbq_debug_qualifier_test.sv
module dbq_debug_qualifier_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        feat_en = 1'b0, bp_hit = 1'b0, wp_hit = 1'b0;
    logic [1:0]  bp_priv = 2'd0;
    logic [63:0] wp_ctl = '0;
    logic        st_pr = 1'b0, st_hv = 1'b0, st_dr = 1'b0;
    logic        bp_fire, wp_fire;
    logic [63:0] wp_status, bp_err;

    localparam logic [63:0] STS_EXP = 64'h0000_0000_0040_0000;
    localparam logic [63:0] ERR_EXP = 64'h0000_0000_4010_0000;
    // control word field values (LSB-0): match 0x10, ignore 0x08, hv 0x04, sv 0x02, pr 0x01
    localparam logic [63:0] C_XM = 64'h10, C_XI = 64'h08, C_HV = 64'h04, C_SV = 64'h02, C_PR = 64'h01;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic  bp;
        logic  wp;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    dbq_debug_qualifier uut (
        .clk(clk), .rst_n(rst_n), .feat_en(feat_en),
        .bp_hit(bp_hit), .bp_priv(bp_priv), .wp_hit(wp_hit), .wp_ctl(wp_ctl),
        .st_pr(st_pr), .st_hv(st_hv), .st_dr(st_dr),
        .bp_fire(bp_fire), .wp_fire(wp_fire), .wp_status(wp_status), .bp_err(bp_err)
    );

    function automatic logic exp_bp(input logic en, input logic h, input logic [1:0] c,
                                    input logic pr, input logic hv);
        logic ok;
        case (c)
            2'd1:    ok = pr;                 // R2
            2'd2:    ok = !pr && !hv;         // R3
            2'd3:    ok = !pr && hv;          // R4
            default: ok = 1'b0;               // R5
        endcase
        return en && h && ok;                 // R1
    endfunction

    function automatic logic exp_wp(input logic en, input logic h, input logic [63:0] c,
                                    input logic pr, input logic hv, input logic dr);
        logic ok;
        ok = 1'b1;
        if (pr && (c & C_PR) == 0) ok = 1'b0;        // R6
        if (hv && (c & C_HV) == 0) ok = 1'b0;        // R7
        if ((c & C_SV) == 0) ok = 1'b0;              // R7
        if ((c & C_XI) == 0 && (((c & C_XM) != 0) != dr)) ok = 1'b0; // R8
        return en && h && ok;
    endfunction

    task automatic drive(input logic en, input logic bh, input logic [1:0] bc,
                         input logic wh, input logic [63:0] wc,
                         input logic pr, input logic hv, input logic dr, input string tag);
        exp_t e;
        @(negedge clk);
        feat_en = en; bp_hit = bh; bp_priv = bc; wp_hit = wh; wp_ctl = wc;
        st_pr = pr; st_hv = hv; st_dr = dr;
        e.bp  = exp_bp(en, bh, bc, pr, hv);
        e.wp  = exp_wp(en, wh, wc, pr, hv, dr);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares one expected item per clock, after the edge settles.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (bp_fire !== e.bp || wp_fire !== e.wp) begin
                    fails++;
                    $display("FAIL %s fire bp=%0b wp=%0b expected bp=%0b wp=%0b",
                             e.tag, bp_fire, wp_fire, e.bp, e.wp);
                end
                checks++;
                if (wp_status !== (e.wp ? STS_EXP : 64'h0)) begin
                    fails++;
                    $display("FAIL R9 status=%h expected %h", wp_status, e.wp ? STS_EXP : 64'h0);
                end
                checks++;
                if (bp_err !== (e.bp ? ERR_EXP : 64'h0)) begin
                    fails++;
                    $display("FAIL R10 err=%h expected %h", bp_err, e.bp ? ERR_EXP : 64'h0);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R12: outputs zero in reset even with live hits
        feat_en = 1'b1; bp_hit = 1'b1; bp_priv = 2'd1; st_pr = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (bp_fire !== 1'b0 || wp_fire !== 1'b0 || wp_status !== 64'h0 || bp_err !== 64'h0) begin
            fails++;
            $display("FAIL R12 reset outputs bp=%0b wp=%0b expected 0", bp_fire, wp_fire);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: disabled, otherwise fully qualifying inputs
        drive(1'b0, 1'b1, 2'd1, 1'b1, C_PR | C_SV | C_HV | C_XI, 1'b1, 1'b0, 1'b0, "R1");
        drive(1'b0, 1'b1, 2'd3, 1'b1, C_SV | C_HV | C_XI, 1'b0, 1'b1, 1'b1, "R1");

        // R2 R3 R4 R5: privilege code sweep
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 4; s++) begin
                string t;
                t = (c == 0) ? "R5" : (c == 1) ? "R2" : (c == 2) ? "R3" : "R4";
                drive(1'b1, 1'b1, 2'(c), 1'b0, 64'h0, s[0], s[1], 1'b0, t);
            end
        end

        // R6 R7 R8: control word and state sweep
        for (int w = 0; w < 32; w++) begin
            for (int s = 0; s < 8; s++) begin
                drive(1'b1, 1'b0, 2'd0, 1'b1, 64'(w), s[0], s[1], s[2], "R6_R7_R8");
            end
        end

        // R11: hit then idle clears; back-to-back both kinds
        drive(1'b1, 1'b1, 2'd2, 1'b1, C_SV | C_XI, 1'b0, 1'b0, 1'b1, "R11");
        drive(1'b1, 1'b0, 2'd2, 1'b0, C_SV | C_XI, 1'b0, 1'b0, 1'b1, "R11");
        drive(1'b1, 1'b1, 2'd3, 1'b1, C_SV | C_HV | C_XM, 1'b0, 1'b1, 1'b1, "R11");
        drive(1'b1, 1'b1, 2'd3, 1'b1, C_SV | C_HV | C_XM, 1'b0, 1'b1, 1'b1, "R11");
        drive(1'b0, 1'b0, 2'd0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, "R11");

        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule